// File: doc/BRIEF.md
# Command-Driven Control and Status Register Bank

This block is the host-visible register bank of a vector interface unit that consumes a command stream. A word-wide write port and a combinational read port both select a register by a small index. One index is a write-only command word whose action bits (clear status, request stop, force a break, soft reset) become status flag updates and control pulses toward the engine. The host may write only the command word, the error-mask register and the mark register. Every other register is owned by the engine: the engine loads it, and the host can only read it.

The engine reports events through single-cycle pulses: mark reached, interrupt, interrupt stall, two error kinds, and an acknowledgement that a pending stop was taken at an instruction boundary. The block drives a combined `stall` level, a pending-stop level, an engine reset pulse and a queue-flush pulse. The flush pulse tells the queue to move its read pointer past the last entry it holds. A parameter picks which of two units this instance is. Only the second unit holds the five double-buffer registers. In the first unit those indices read as zero and reject writes.

Top module: `vcr_ctrl_regs`

## Requirements
- R1: After reset every register index reads zero and `stall` and `stop_req` are low. The command word (index 1) always reads as zero.
- R2: Command bit 0 (clear status) zeroes status bits 0 (stop stall), 1 (break stall), 2 (interrupt stall), 4 (interrupt), 5 (error A) and 6 (error B). It also cancels a pending stop. It leaves status bit 3 (mark flag) unchanged.
- R3: Command bit 1 (stop) raises only `stop_req`; the status word does not change. An `ev_stop_take` pulse while a stop is pending sets status bit 0 and drops `stop_req`.
- R4: Command bit 2 (break) sets status bit 0x2. `stall` is high whenever status bit 0, 1 or 2 is set.
- R5: When one command write sets several bits, the bits apply in this order: clear, stop, break, reset. So 0x3 leaves a stop pending, 0x5 leaves the break stall set, and any value with bit 3 set leaves everything zero.
- R6: Command bit 3 (reset) clears every register, flag and pending stop. It drives `eng_rst` and `q_flush` high for exactly the one cycle after the write.
- R7: A host write to the error-mask register (index 2) stores only data bits 2:0.
- R8: A host write to the mark register (index 3) stores data bits 15:0 and clears status bit 3.
- R9: Host writes to the status word (index 0) and to engine-owned indices 4 to 23 change nothing. Every rejected write pulses `wr_err` for one cycle, in the cycle after the write. Engine loads to indices 4 to 23 read back through the host port.
- R10: Indices 11 to 15 are double-buffer registers. When `UNIT_ID` is 1 they are engine-loadable and readable. When `UNIT_ID` is 0 they read zero and ignore engine loads. In both cases host writes to them are rejected.
- R11: When an engine event pulse falls in the same cycle as a host clear status or a mark write, the event's flag is still set afterwards. A reset command in the same cycle as engine events or loads wins, and everything reads zero.
- R12: Indices from 24 up read zero, and writes to them are rejected.
- R13: Asserting `rst_n` low clears all state at once without pulsing `q_flush` or `eng_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | IW | Host write register index |
| wr_data | input | DW | Host write data |
| rd_idx | input | IW | Host read register index |
| rd_data | output | DW | Read data for `rd_idx` (combinational) |
| wr_err | output | 1 | One-cycle pulse after a rejected host write |
| eng_ld | input | 1 | Engine register load strobe |
| eng_idx | input | IW | Engine load register index |
| eng_data | input | DW | Engine load data |
| ev_mark | input | 1 | Engine event: set mark flag |
| ev_int | input | 1 | Engine event: set interrupt flag |
| ev_istall | input | 1 | Engine event: set interrupt stall |
| ev_err0 | input | 1 | Engine event: set error A |
| ev_err1 | input | 1 | Engine event: set error B |
| ev_stop_take | input | 1 | Engine takes a pending stop at an instruction boundary |
| stop_req | output | 1 | A stop request is pending |
| stall | output | 1 | Engine must hold (stop, break or interrupt stall) |
| eng_rst | output | 1 | One-cycle soft reset pulse to the engine |
| q_flush | output | 1 | One-cycle pulse: discard all queued entries |

## Verification
Two functions can act on the same flag in the same cycle. One is a host command write (clear status, a mark write, or a reset command). The other is an engine event pulse or an engine register load. The bench drives both in one cycle: clear status together with `ev_int`, a mark write together with `ev_mark`, and a reset command together with `ev_int` and an engine load. It then reads the status word and the loaded register. The expected result is that the event survives a clear or mark write, and that reset overrides every event and load.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  // register indices (behaviour depends on the grouping, not on the numbers)
  localparam int IDX_STAT      = 0;
  localparam int IDX_CMD       = 1;
  localparam int IDX_ERRM      = 2;
  localparam int IDX_MARK      = 3;
  localparam int IDX_CYCLE     = 4;   // first engine-owned index
  localparam int IDX_BUF_FIRST = 11;  // double-buffer group start
  localparam int IDX_BUF_LAST  = 15;  // double-buffer group end
  localparam int IDX_ROW0      = 16;
  localparam int IDX_COL0      = 20;
  localparam int NUM_REGS      = 24;

  // command action bits, applied low to high
  localparam int CMD_CLR  = 0;
  localparam int CMD_STOP = 1;
  localparam int CMD_BRK  = 2;
  localparam int CMD_RST  = 3;

  localparam int ERRM_W = 3;
  localparam int MARK_W = 16;

  typedef struct packed {
    logic err_b;    // bit 6
    logic err_a;    // bit 5
    logic irq;      // bit 4
    logic mark;     // bit 3
    logic int_stl;  // bit 2
    logic brk_stl;  // bit 1
    logic stop_stl; // bit 0
  } stat_t;

  localparam int STAT_W = $bits(stat_t);
endpackage

// File: rtl/vcr_decode.sv
module vcr_decode
  import vcr_pkg::*;
#(
  parameter int IW      = 5,
  parameter int UNIT_ID = 1
) (
  input  logic [IW-1:0] idx,
  output logic          host_ok,
  output logic          is_cmd,
  output logic          is_errm,
  output logic          is_mark,
  output logic          readable,
  output logic          eng_owned
);
  localparam bit HAS_BUF = (UNIT_ID != 0);

  int   i;
  logic in_buf;
  logic fitted;

  always_comb begin
    i         = int'(idx);
    in_buf    = (i >= IDX_BUF_FIRST) && (i <= IDX_BUF_LAST);
    fitted    = (i < NUM_REGS) && !(in_buf && !HAS_BUF);
    is_cmd    = (i == IDX_CMD);
    is_errm   = (i == IDX_ERRM);
    is_mark   = (i == IDX_MARK);
    host_ok   = is_cmd || is_errm || is_mark;
    readable  = fitted && !is_cmd;
    eng_owned = fitted && (i >= IDX_CYCLE);
  end
endmodule

// File: rtl/vcr_status.sv
module vcr_status
  import vcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [3:0] cmd_bits,
  input  logic       mark_wr,
  input  logic       ev_mark,
  input  logic       ev_int,
  input  logic       ev_istall,
  input  logic       ev_err0,
  input  logic       ev_err1,
  input  logic       ev_stop_take,
  output stat_t      stat,
  output logic       stop_pend
);
  stat_t stat_d;
  logic  pend_d;
  logic  upd_en;

  // next state: host command first, engine events on top, reset last
  always_comb begin
    stat_d = stat;
    pend_d = stop_pend;
    if (cmd_wr) begin
      if (cmd_bits[CMD_CLR]) begin
        stat_d.stop_stl = 1'b0;
        stat_d.brk_stl  = 1'b0;
        stat_d.int_stl  = 1'b0;
        stat_d.irq      = 1'b0;
        stat_d.err_a    = 1'b0;
        stat_d.err_b    = 1'b0;
        pend_d          = 1'b0;
      end
      if (cmd_bits[CMD_STOP]) pend_d = 1'b1;
      if (cmd_bits[CMD_BRK])  stat_d.brk_stl = 1'b1;
    end
    if (mark_wr)   stat_d.mark    = 1'b0;
    if (ev_mark)   stat_d.mark    = 1'b1;
    if (ev_int)    stat_d.irq     = 1'b1;
    if (ev_istall) stat_d.int_stl = 1'b1;
    if (ev_err0)   stat_d.err_a   = 1'b1;
    if (ev_err1)   stat_d.err_b   = 1'b1;
    if (ev_stop_take && pend_d) begin
      stat_d.stop_stl = 1'b1;
      pend_d          = 1'b0;
    end
    if (cmd_wr && cmd_bits[CMD_RST]) begin
      stat_d = '0;
      pend_d = 1'b0;
    end
  end

  assign upd_en = cmd_wr || mark_wr || ev_mark || ev_int || ev_istall ||
                  ev_err0 || ev_err1 || ev_stop_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat      <= '0;
      stop_pend <= 1'b0;
    end else if (upd_en) begin
      stat      <= stat_d;
      stop_pend <= pend_d;
    end
  end
endmodule

// File: rtl/vcr_store.sv
module vcr_store
  import vcr_pkg::*;
#(
  parameter int DW      = 32,
  parameter int IW      = 5,
  parameter int UNIT_ID = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic [IW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_val
);
  localparam bit HAS_BUF = (UNIT_ID != 0);

  logic [DW-1:0] q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    if (g < IDX_CYCLE) begin : g_host
      assign q[g] = '0;
    end else if (!HAS_BUF && g >= IDX_BUF_FIRST && g <= IDX_BUF_LAST) begin : g_absent
      assign q[g] = '0;
    end else begin : g_live
      logic [DW-1:0] r;
      logic          en;
      assign en = clr || (ld && (ld_idx == IW'(g)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  r <= '0;
        else if (en) r <= clr ? '0 : ld_data;
      end
      assign q[g] = r;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (rd_idx == IW'(k)) rd_val = q[k];
  end
endmodule

// File: rtl/vcr_ctrl_regs.sv
module vcr_ctrl_regs
  import vcr_pkg::*;
#(
  parameter int DW      = 32,
  parameter int IW      = 5,
  parameter int UNIT_ID = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          wr_err,
  input  logic          eng_ld,
  input  logic [IW-1:0] eng_idx,
  input  logic [DW-1:0] eng_data,
  input  logic          ev_mark,
  input  logic          ev_int,
  input  logic          ev_istall,
  input  logic          ev_err0,
  input  logic          ev_err1,
  input  logic          ev_stop_take,
  output logic          stop_req,
  output logic          stall,
  output logic          eng_rst,
  output logic          q_flush
);
  logic w_ok, w_cmd, w_errm, w_mark, w_rd, w_eng;
  logic r_ok, r_cmd, r_errm, r_mark, r_rd, r_eng;
  logic e_ok, e_cmd, e_errm, e_mark, e_rd, e_eng;

  vcr_decode #(.IW(IW), .UNIT_ID(UNIT_ID)) u_dec_wr (
    .idx(wr_idx), .host_ok(w_ok), .is_cmd(w_cmd), .is_errm(w_errm),
    .is_mark(w_mark), .readable(w_rd), .eng_owned(w_eng));
  vcr_decode #(.IW(IW), .UNIT_ID(UNIT_ID)) u_dec_rd (
    .idx(rd_idx), .host_ok(r_ok), .is_cmd(r_cmd), .is_errm(r_errm),
    .is_mark(r_mark), .readable(r_rd), .eng_owned(r_eng));
  vcr_decode #(.IW(IW), .UNIT_ID(UNIT_ID)) u_dec_eng (
    .idx(eng_idx), .host_ok(e_ok), .is_cmd(e_cmd), .is_errm(e_errm),
    .is_mark(e_mark), .readable(e_rd), .eng_owned(e_eng));

  logic cmd_wr, rst_cmd, errm_wr, mark_wr, bad_wr, eng_go;
  assign cmd_wr  = wr_en && w_cmd;
  assign rst_cmd = cmd_wr && wr_data[CMD_RST];
  assign errm_wr = wr_en && w_errm;
  assign mark_wr = wr_en && w_mark;
  assign bad_wr  = wr_en && !w_ok;
  assign eng_go  = eng_ld && e_eng;

  stat_t stat;
  logic  stop_pend;

  vcr_status u_stat (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_bits(wr_data[3:0]),
    .mark_wr(mark_wr), .ev_mark(ev_mark), .ev_int(ev_int),
    .ev_istall(ev_istall), .ev_err0(ev_err0), .ev_err1(ev_err1),
    .ev_stop_take(ev_stop_take), .stat(stat), .stop_pend(stop_pend));

  logic [DW-1:0] eng_val;

  vcr_store #(.DW(DW), .IW(IW), .UNIT_ID(UNIT_ID)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(rst_cmd), .ld(eng_go), .ld_idx(eng_idx),
    .ld_data(eng_data), .rd_idx(rd_idx), .rd_val(eng_val));

  // host-owned storage: next state and register processes
  logic [ERRM_W-1:0] errm_q, errm_d;
  logic [MARK_W-1:0] mark_q, mark_d;
  logic              host_en;
  logic              pulse_en;

  always_comb begin
    errm_d = errm_q;
    mark_d = mark_q;
    if (errm_wr) errm_d = wr_data[ERRM_W-1:0];
    if (mark_wr) mark_d = wr_data[MARK_W-1:0];
    if (rst_cmd) begin
      errm_d = '0;
      mark_d = '0;
    end
  end

  assign host_en  = errm_wr || mark_wr || rst_cmd;
  assign pulse_en = rst_cmd || eng_rst || bad_wr || wr_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errm_q <= '0;
      mark_q <= '0;
    end else if (host_en) begin
      errm_q <= errm_d;
      mark_q <= mark_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_rst <= 1'b0;
      q_flush <= 1'b0;
      wr_err  <= 1'b0;
    end else if (pulse_en) begin
      eng_rst <= rst_cmd;
      q_flush <= rst_cmd;
      wr_err  <= bad_wr;
    end
  end

  // read path
  always_comb begin
    rd_data = '0;
    if (r_rd) begin
      if (rd_idx == IW'(IDX_STAT))  rd_data[STAT_W-1:0] = stat;
      else if (r_errm)              rd_data[ERRM_W-1:0] = errm_q;
      else if (r_mark)              rd_data[MARK_W-1:0] = mark_q;
      else if (r_eng)               rd_data = eng_val;
    end
  end

  assign stop_req = stop_pend;
  assign stall    = stat.stop_stl || stat.brk_stl || stat.int_stl;
endmodule

// File: rtl/vcr_ctrl_regs_chk.sv
module vcr_ctrl_regs_chk
  import vcr_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [DW-1:0] wr_data,
  input logic [IW-1:0] rd_idx,
  input logic [DW-1:0] rd_data,
  input logic          wr_err,
  input logic          ev_istall,
  input logic          ev_stop_take,
  input logic          stop_req,
  input logic          stall,
  input logic          eng_rst,
  input logic          q_flush
);
  logic cmd_w;
  assign cmd_w = wr_en && (wr_idx == IW'(IDX_CMD));

  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == IW'(IDX_CMD)) |-> (rd_data == '0)); // R1
  AST_STOP_ONLY_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && wr_data[3:0] == 4'b0010 && !stall && !ev_stop_take && !ev_istall)
      |=> (stop_req && !stall)); // R3
  AST_BREAK_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && wr_data[CMD_BRK] && !wr_data[CMD_RST]) |=> stall); // R4
  AST_RESET_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && wr_data[CMD_RST]) |=> (eng_rst && q_flush && !stall && !stop_req)); // R6
  AST_ERRM_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == IW'(IDX_ERRM)) |-> (rd_data[DW-1:ERRM_W] == '0)); // R7
  AST_MARK_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == IW'(IDX_MARK)) |-> (rd_data[DW-1:MARK_W] == '0)); // R8
  AST_RO_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IW'(IDX_CYCLE)) |=> wr_err); // R9
endmodule

bind vcr_ctrl_regs vcr_ctrl_regs_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_idx(rd_idx), .rd_data(rd_data), .wr_err(wr_err), .ev_istall(ev_istall),
  .ev_stop_take(ev_stop_take), .stop_req(stop_req), .stall(stall),
  .eng_rst(eng_rst), .q_flush(q_flush));

// File: tb/sim_vcr_ctrl_regs.sv
module sim_vcr_ctrl_regs;
  localparam int DW = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          wr_en;
  logic [IW-1:0] wr_idx, rd_idx, eng_idx;
  logic [DW-1:0] wr_data, eng_data;
  logic          eng_ld, ev_mark, ev_int, ev_istall, ev_err0, ev_err1, ev_stop_take;

  logic [DW-1:0] rd0, rd1;
  logic          err0, err1, sreq0, sreq1, stl0, stl1, erst0, erst1, fl0, fl1;

  vcr_ctrl_regs #(.DW(DW), .IW(IW), .UNIT_ID(1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd0), .wr_err(err0), .eng_ld(eng_ld),
    .eng_idx(eng_idx), .eng_data(eng_data), .ev_mark(ev_mark), .ev_int(ev_int),
    .ev_istall(ev_istall), .ev_err0(ev_err0), .ev_err1(ev_err1),
    .ev_stop_take(ev_stop_take), .stop_req(sreq0), .stall(stl0),
    .eng_rst(erst0), .q_flush(fl0));

  vcr_ctrl_regs #(.DW(DW), .IW(IW), .UNIT_ID(0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd1), .wr_err(err1), .eng_ld(eng_ld),
    .eng_idx(eng_idx), .eng_data(eng_data), .ev_mark(ev_mark), .ev_int(ev_int),
    .ev_istall(ev_istall), .ev_err0(ev_err0), .ev_err1(ev_err1),
    .ev_stop_take(ev_stop_take), .stop_req(sreq1), .stall(stl1),
    .eng_rst(erst1), .q_flush(fl1));

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input int idx, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input int idx, output logic [DW-1:0] v0, output logic [DW-1:0] v1);
    rd_idx = IW'(idx);
    #1;
    v0 = rd0; v1 = rd1;
  endtask

  task automatic eng_load(input int idx, input logic [DW-1:0] d);
    @(negedge clk);
    eng_ld = 1'b1; eng_idx = IW'(idx); eng_data = d;
    @(negedge clk);
    eng_ld = 1'b0;
  endtask

  typedef struct packed {
    logic [7:0]    widx;
    logic [DW-1:0] wdata;
    logic [7:0]    ridx;
    logic [DW-1:0] rexp;
    logic          eexp;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{8'd2,  32'hFFFF_FFFF, 8'd2,  32'h0000_0007, 1'b0, 8'd7},  // R7
    '{8'd3,  32'hABCD_1234, 8'd3,  32'h0000_1234, 1'b0, 8'd8},  // R8
    '{8'd4,  32'h0000_0055, 8'd4,  32'h0000_0000, 1'b1, 8'd9},  // R9
    '{8'd0,  32'h0000_00FF, 8'd0,  32'h0000_0000, 1'b1, 8'd9},  // R9
    '{8'd18, 32'h0000_0001, 8'd18, 32'h0000_0000, 1'b1, 8'd9},  // R9
    '{8'd14, 32'h0000_0001, 8'd14, 32'h0000_0000, 1'b1, 8'd10}, // R10
    '{8'd1,  32'h0000_0004, 8'd0,  32'h0000_0002, 1'b0, 8'd4},  // R4
    '{8'd1,  32'h0000_0001, 8'd0,  32'h0000_0000, 1'b0, 8'd2},  // R2
    '{8'd1,  32'h0000_000F, 8'd2,  32'h0000_0000, 1'b0, 8'd5},  // R5
    '{8'd25, 32'h0000_0009, 8'd25, 32'h0000_0000, 1'b1, 8'd12}, // R12
    '{8'd1,  32'h0000_0005, 8'd0,  32'h0000_0002, 1'b0, 8'd5},  // R5
    '{8'd1,  32'h0000_0001, 8'd0,  32'h0000_0000, 1'b0, 8'd2}   // R2
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] a, b;
    logic          e;
    string         tag;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx = '0;
    eng_ld = 1'b0; eng_idx = '0; eng_data = '0; ev_mark = 1'b0; ev_int = 1'b0;
    ev_istall = 1'b0; ev_err0 = 1'b0; ev_err1 = 1'b0; ev_stop_take = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 32; k++) begin
      rd(k, a, b);
      check("R1 reset read", a | b, '0);
    end
    check("R1 stall/stop_req", {30'd0, stl0, sreq0}, '0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      do_wr(int'(VT[v].widx), VT[v].wdata);
      e = err0;
      rd(int'(VT[v].ridx), a, b);
      tag = $sformatf("R%0d vec%0d", VT[v].req, v);
      check({tag, " data"}, a, VT[v].rexp);
      check({tag, " werr"}, {31'd0, e}, {31'd0, VT[v].eexp});
    end

    // R1 command reads zero after writing
    do_wr(1, 32'h0000_0002);
    rd(1, a, b);
    check("R1 cmd read", a, '0);
    // R3 stop pends only
    check("R3 stop_req", {31'd0, sreq0}, 32'd1);
    check("R3 no stall", {31'd0, stl0}, 32'd0);
    rd(0, a, b);
    check("R3 stat unchanged", a, '0);
    @(negedge clk); ev_stop_take = 1'b1;
    @(negedge clk); ev_stop_take = 1'b0;
    rd(0, a, b);
    check("R3 taken stat", a, 32'h1);
    check("R3 taken stall/req", {30'd0, stl0, sreq0}, 32'h2);

    // R2 clear cancels pending stop; R5 clear+stop leaves pending
    do_wr(1, 32'h0000_0002);
    do_wr(1, 32'h0000_0001);
    check("R2 pending cancelled", {31'd0, sreq0}, 32'd0);
    check("R2 stall cleared", {31'd0, stl0}, 32'd0);
    do_wr(1, 32'h0000_0003);
    check("R5 clear then stop", {31'd0, sreq0}, 32'd1);
    do_wr(1, 32'h0000_0001);

    // R2 events cleared, mark kept; R4 stall on interrupt stall
    @(negedge clk);
    ev_mark = 1; ev_int = 1; ev_istall = 1; ev_err0 = 1; ev_err1 = 1;
    @(negedge clk);
    ev_mark = 0; ev_int = 0; ev_istall = 0; ev_err0 = 0; ev_err1 = 0;
    rd(0, a, b);
    check("R4 all events stat", a, 32'h7C);
    check("R4 istall stalls", {31'd0, stl0}, 32'd1);
    do_wr(1, 32'h0000_0001);
    rd(0, a, b);
    check("R2 clear keeps mark", a, 32'h08);
    // R8 mark write clears mark flag
    do_wr(3, 32'h0000_00AA);
    rd(0, a, b);
    check("R8 mark flag cleared", a, 32'h0);

    // R9 engine load visible, host write rejected
    eng_load(16, 32'hCAFE_0001);
    rd(16, a, b);
    check("R9 engine row load", a, 32'hCAFE_0001);
    do_wr(16, 32'h1111_1111);
    e = err0;
    rd(16, a, b);
    check("R9 row unchanged", a, 32'hCAFE_0001);
    check("R9 wr_err", {31'd0, e}, 32'd1);
    @(negedge clk);
    check("R9 wr_err one cycle", {31'd0, err0}, 32'd0);

    // R10 buffer group per unit
    eng_load(11, 32'h0000_BEEF);
    rd(11, a, b);
    check("R10 unit1 buffer reg", a, 32'h0000_BEEF);
    check("R10 unit0 buffer reg", b, 32'h0);
    do_wr(11, 32'h1);
    check("R10 host write rejected", {30'd0, err1, err0}, 32'h3);

    // R11 same-cycle event vs clear, event vs mark write
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(1); wr_data = 32'h1; ev_int = 1;
    @(negedge clk);
    wr_en = 0; wr_data = '0; ev_int = 0;
    rd(0, a, b);
    check("R11 int survives clear", a, 32'h10);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(3); wr_data = 32'h5; ev_mark = 1;
    @(negedge clk);
    wr_en = 0; wr_data = '0; ev_mark = 0;
    rd(0, a, b);
    check("R11 mark survives mark write", a, 32'h18);

    // R11 + R6 reset command wins over load and event; pulses
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(1); wr_data = 32'h8; ev_int = 1;
    eng_ld = 1; eng_idx = IW'(17); eng_data = 32'h1234_5678;
    @(negedge clk);
    wr_en = 0; wr_data = '0; ev_int = 0; eng_ld = 0;
    check("R6 eng_rst/q_flush high", {30'd0, erst0, fl0}, 32'h3);
    rd(0, a, b);
    check("R11 reset beats event", a, 32'h0);
    rd(17, a, b);
    check("R11 reset beats load", a, 32'h0);
    rd(16, a, b);
    check("R6 row cleared", a, 32'h0);
    rd(11, a, b);
    check("R6 buffer cleared", a, 32'h0);
    rd(3, a, b);
    check("R6 mark cleared", a, 32'h0);
    @(negedge clk);
    check("R6 pulses one cycle", {30'd0, erst0, fl0}, 32'h0);

    // R13 async reset
    eng_load(20, 32'h0000_0042);
    do_wr(2, 32'h5);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd(20, a, b);
    check("R13 col cleared", a, 32'h0);
    rd(2, a, b);
    check("R13 errm cleared", a, 32'h0);
    check("R13 no flush", {30'd0, erst0, fl0}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule